// File: doc/BRIEF.md
# Integer ALU with Shifts

This block is the combinational integer execution unit of a simple load/store processor core. It takes two data operands, a separate shift amount and a 4-bit operation code. From these it returns one result word, an equality flag and a signed-overflow flag. The surrounding datapath chooses the operands: register values, a sign- or zero-extended immediate, or a register-held shift count. The unit itself never looks at instruction fields.

Its operation set covers:
- wrapping and overflow-reporting addition and subtraction;
- the four bitwise logic functions, including NOR;
- signed and unsigned set-on-less-than;
- left, logical-right and arithmetic-right shifts of operand B;
- upper-immediate placement, which moves the low half of operand B into the high half of the result.

The equality flag compares A with B on every cycle, whatever the operation. A branch therefore needs no dedicated subtract.

Top module: `int_alu`

## Requirements
- R1: Op code 0 (add, reporting) and op code 1 (add, wrapping) return A+B modulo 2^32.
- R2: Op code 2 (subtract, reporting) and op code 3 (subtract, wrapping) return A-B modulo 2^32.
- R3: The overflow output is 1 only for op code 0 when A and B have equal signs and the sum's sign differs, or for op code 2 when A and B have different signs and the difference's sign differs from A. The output is 0 for every other op code, including 1 and 3.
- R4: Op codes 4, 5 and 6 return A AND B, A OR B and A XOR B.
- R5: Op code 7 returns the bitwise inverse of (A OR B).
- R6: Op code 8 returns 1 when A is less than B as two's-complement numbers, and 0 otherwise. Bits 31:1 are always 0.
- R7: Op code 9 returns 1 when A is less than B as unsigned numbers, and 0 otherwise.
- R8: Op code 10 shifts B left by the 5-bit shift amount and fills with zeros. An amount of 0 returns B unchanged.
- R9: Op code 11 shifts B right by the shift amount and fills with zeros.
- R10: Op code 12 shifts B right by the shift amount and fills the vacated bits with copies of B bit 31.
- R11: Op code 13 returns B[15:0] in bits 31:16, with bits 15:0 cleared.
- R12: The equal output is 1 exactly when A equals B, whatever the op code.
- R13: Op codes 14 and 15 return a zero result with overflow 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand (rs value) |
| opnd_b | input | 32 | Second operand (rt value or extended immediate); the shifted value for shifts |
| shamt | input | 5 | Shift amount |
| op_sel | input | 4 | Operation code, see requirements |
| result | output | 32 | Operation result |
| equal | output | 1 | A equals B |
| ovf | output | 1 | Signed overflow on reporting add/sub |

## Verification
The equality flag and the overflow flag come from different logic, yet both are valid during a subtract. The bench therefore subtracts operands that are equal, that differ by one near the signed extremes, and that differ only in sign. It judges both flags and the result in the same sample. Random stimulus makes one operand equal to the other a quarter of the time, so `equal` is also seen high under every other op code. Each sample is compared against a reference function that the bench computes from the requirements.

// File: rtl/alu_pkg.sv
package alu_pkg;
   typedef enum logic [3:0] {
      ALU_ADD  = 4'd0,
      ALU_ADDU = 4'd1,
      ALU_SUB  = 4'd2,
      ALU_SUBU = 4'd3,
      ALU_AND  = 4'd4,
      ALU_OR   = 4'd5,
      ALU_XOR  = 4'd6,
      ALU_NOR  = 4'd7,
      ALU_SLT  = 4'd8,
      ALU_SLTU = 4'd9,
      ALU_SLL  = 4'd10,
      ALU_SRL  = 4'd11,
      ALU_SRA  = 4'd12,
      ALU_LUI  = 4'd13
   } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   output logic [DATA_W-1:0] sum,
   output logic              carry,
   output logic              ovf_raw
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;

   assign b_eff = sub ? ~b : b;
   assign {carry, sum} = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
   assign ovf_raw = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

   always_comb begin
      if (!$isunknown({a, b, sub})) begin
         // R2: subtracting equal values gives zero with no borrow
         p_equal_sub_zero_r2: assert (!(sub && a == b) || (sum == '0 && carry))
            else $error("equal subtract not zero");
      end
   end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int DATA_W    = 32,
   parameter int SHAMT_W   = $clog2(DATA_W),
   parameter bit LOG_STAGE = 1'b1
) (
   input  logic [DATA_W-1:0]  value,
   input  logic [SHAMT_W-1:0] amt,
   input  logic               arith,
   output logic [DATA_W-1:0]  left,
   output logic [DATA_W-1:0]  right
);
   localparam int MSB = DATA_W - 1;

   logic fill;
   assign fill = arith & value[MSB];

   generate
      if (LOG_STAGE) begin : g_log
         logic [DATA_W-1:0] ls [0:SHAMT_W];
         logic [DATA_W-1:0] rs [0:SHAMT_W];
         assign ls[0] = value;
         assign rs[0] = value;
         for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
            localparam int D = 1 << k;
            assign ls[k+1] = amt[k] ? {ls[k][DATA_W-1-D:0], {D{1'b0}}} : ls[k];
            assign rs[k+1] = amt[k] ? {{D{fill}}, rs[k][DATA_W-1:D]} : rs[k];
         end
         assign left  = ls[SHAMT_W];
         assign right = rs[SHAMT_W];
      end else begin : g_flat
         logic [2*DATA_W-1:0] ext;
         assign ext   = {{DATA_W{fill}}, value} >> amt;
         assign left  = value << amt;
         assign right = ext[DATA_W-1:0];
      end
   endgenerate

   always_comb begin
      if (!$isunknown({value, amt, arith})) begin
         // R9: logical right shift by a nonzero amount clears the top bit
         p_srl_zero_fill_r9: assert (arith || amt == '0 || !right[MSB])
            else $error("logical right shift filled with one");
         // R10: arithmetic right shift keeps the sign
         p_sra_sign_keep_r10: assert (!arith || right[MSB] == value[MSB])
            else $error("arithmetic right shift lost sign");
         // R8: left shift never sets bits below the amount
         p_sll_low_zero_r8: assert (amt == '0 || left[0] == 1'b0)
            else $error("left shift low bit set");
      end
   end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [1:0]        fn,
   output logic [DATA_W-1:0] y
);
   always_comb begin
      unique case (fn)
         2'd0: y = a & b;
         2'd1: y = a | b;
         2'd2: y = a ^ b;
         default: y = ~(a | b);
      endcase
   end

   always_comb begin
      if (!$isunknown({a, b, fn})) begin
         // R5: NOR output shares no set bit with either operand
         p_nor_disjoint_r5: assert (fn != 2'd3 || (y & (a | b)) == '0)
            else $error("nor overlaps operand");
      end
   end
endmodule

// File: rtl/int_alu.sv
module int_alu
   import alu_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit LOG_SHIFT = 1'b1,
   localparam int SHAMT_W  = $clog2(DATA_W),
   localparam int IMM_W    = DATA_W / 2
) (
   input  logic [DATA_W-1:0]  opnd_a,
   input  logic [DATA_W-1:0]  opnd_b,
   input  logic [SHAMT_W-1:0] shamt,
   input  logic [3:0]         op_sel,
   output logic [DATA_W-1:0]  result,
   output logic               equal,
   output logic               ovf
);
   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 8 || (1 << SHAMT_W) != DATA_W) begin : g_bad_width
         $error("int_alu: DATA_W must be a power of two, at least 8");
      end
   endgenerate

   alu_op_e op;
   assign op = alu_op_e'(op_sel);

   logic              do_sub, ovf_raw, carry;
   logic [DATA_W-1:0] sum, logic_y, sh_left, sh_right;
   logic              lt_signed, lt_unsigned;

   assign do_sub = (op == ALU_SUB) || (op == ALU_SUBU) ||
                   (op == ALU_SLT) || (op == ALU_SLTU);

   alu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a(opnd_a), .b(opnd_b), .sub(do_sub),
      .sum(sum), .carry(carry), .ovf_raw(ovf_raw)
   );

   alu_bitwise #(.DATA_W(DATA_W)) u_logic (
      .a(opnd_a), .b(opnd_b), .fn(op_sel[1:0]), .y(logic_y)
   );

   alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .LOG_STAGE(LOG_SHIFT)) u_shift (
      .value(opnd_b), .amt(shamt), .arith(op == ALU_SRA),
      .left(sh_left), .right(sh_right)
   );

   assign lt_signed   = sum[MSB] ^ ovf_raw;
   assign lt_unsigned = ~carry;

   always_comb begin
      case (op)
         ALU_ADD, ALU_ADDU, ALU_SUB, ALU_SUBU: result = sum;
         ALU_AND, ALU_OR, ALU_XOR, ALU_NOR:    result = logic_y;
         ALU_SLT:  result = {{(DATA_W-1){1'b0}}, lt_signed};
         ALU_SLTU: result = {{(DATA_W-1){1'b0}}, lt_unsigned};
         ALU_SLL:  result = sh_left;
         ALU_SRL, ALU_SRA: result = sh_right;
         ALU_LUI:  result = {opnd_b[IMM_W-1:0], {IMM_W{1'b0}}};
         default:  result = '0;
      endcase
   end

   assign ovf   = ovf_raw && ((op == ALU_ADD) || (op == ALU_SUB));
   assign equal = (opnd_a == opnd_b);

   always_comb begin
      if (!$isunknown({opnd_a, opnd_b, shamt, op_sel})) begin
         // R3: flag only on reporting add or subtract
         p_ovf_ops_r3: assert (!ovf || op == ALU_ADD || op == ALU_SUB)
            else $error("overflow on wrong op");
         // R3: flagged result always has the wrong sign relative to A
         p_ovf_sign_r3: assert (!ovf || result[MSB] != opnd_a[MSB])
            else $error("overflow with consistent sign");
         // R6 / R7: compare results are 0 or 1
         p_setlt_bit_r6: assert (!(op == ALU_SLT || op == ALU_SLTU) || result[MSB:1] == '0)
            else $error("compare result wide");
         // R11: upper-immediate low half clear
         p_lui_low_r11: assert (op != ALU_LUI || result[IMM_W-1:0] == '0)
            else $error("lui low half nonzero");
         // R12: equal flag agrees with subtractor when subtracting
         p_equal_sub_r12: assert (!(op == ALU_SUBU) || (equal == (result == '0)))
            else $error("equal disagrees with difference");
      end
   end
endmodule

// File: tb/sim_int_alu.sv
module sim_int_alu;
   logic        clk = 1'b0;
   logic [31:0] a = '0, b = '0;
   logic [4:0]  sh = '0;
   logic [3:0]  op = '0;
   logic [31:0] res;
   logic        eq, of;
   int          total = 0, fails = 0, cyc = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   int_alu u0 (.opnd_a(a), .opnd_b(b), .shamt(sh), .op_sel(op),
               .result(res), .equal(eq), .ovf(of));

   function automatic logic [31:0] ref_res(input logic [3:0] o, input logic [31:0] x,
                                           input logic [31:0] y, input logic [4:0] s);
      case (o)
         4'd0, 4'd1: return x + y;
         4'd2, 4'd3: return x - y;
         4'd4: return x & y;
         4'd5: return x | y;
         4'd6: return x ^ y;
         4'd7: return ~(x | y);
         4'd8: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
         4'd9: return (x < y) ? 32'd1 : 32'd0;
         4'd10: return y << s;
         4'd11: return y >> s;
         4'd12: return $unsigned($signed(y) >>> s);
         4'd13: return {y[15:0], 16'h0};
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic ref_ovf(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
      logic [31:0] r;
      if (o == 4'd0) begin
         r = x + y;
         return (x[31] == y[31]) && (r[31] != x[31]);
      end
      if (o == 4'd2) begin
         r = x - y;
         return (x[31] != y[31]) && (r[31] != x[31]);
      end
      return 1'b0;
   endfunction

   function automatic string tag_of(input logic [3:0] o);
      case (o)
         4'd0, 4'd1: return "R1";
         4'd2, 4'd3: return "R2";
         4'd4, 4'd5, 4'd6: return "R4";
         4'd7: return "R5";
         4'd8: return "R6";
         4'd9: return "R7";
         4'd10: return "R8";
         4'd11: return "R9";
         4'd12: return "R10";
         4'd13: return "R11";
         default: return "R13";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: op=%0d a=%h b=%h sh=%0d got %h expected %h", tag, op, a, b, sh, got, exp);
      end
   endtask

   task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                        input logic [4:0] s);
      @(posedge clk);
      op = o; a = x; b = y; sh = s;
      @(negedge clk);
      check(tag_of(o), res, ref_res(o, x, y, s));
      check("R3", {31'd0, of}, {31'd0, ref_ovf(o, x, y)});
      check("R12", {31'd0, eq}, {31'd0, x == y});
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         total++; fails++;
         $display("FAIL watchdog (all R): got %0d cycles expected completion", cyc);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      // reset/idle state: all zero inputs, add
      check("R1", res, 32'd0);
      check("R12", {31'd0, eq}, 32'd1);
      check("R3", {31'd0, of}, 32'd0);
      // R3 corners: overflow in add/sub, none in wrapping forms
      apply(4'd0, 32'h7fffffff, 32'h1, 5'd0);
      apply(4'd1, 32'h7fffffff, 32'h1, 5'd0);
      apply(4'd0, 32'h80000000, 32'h80000000, 5'd0);
      apply(4'd2, 32'h80000000, 32'h1, 5'd0);
      apply(4'd3, 32'h80000000, 32'h1, 5'd0);
      apply(4'd2, 32'h7fffffff, 32'hffffffff, 5'd0);
      apply(4'd2, 32'h12345678, 32'h12345678, 5'd0);   // R12 with R2 same cycle
      apply(4'd2, 32'h00000000, 32'h80000000, 5'd0);
      // R6 / R7 sign corners
      apply(4'd8, 32'hffffffff, 32'h1, 5'd0);
      apply(4'd9, 32'hffffffff, 32'h1, 5'd0);
      apply(4'd8, 32'h7fffffff, 32'h80000000, 5'd0);
      apply(4'd9, 32'h5, 32'h5, 5'd0);
      // R8 / R9 / R10 shift extremes
      apply(4'd10, 32'h0, 32'hdeadbeef, 5'd0);
      apply(4'd10, 32'h0, 32'hdeadbeef, 5'd31);
      apply(4'd11, 32'h0, 32'h80000000, 5'd31);
      apply(4'd12, 32'h0, 32'h80000000, 5'd31);
      apply(4'd12, 32'h0, 32'h7fff0000, 5'd16);
      apply(4'd11, 32'h0, 32'hf0f0f0f0, 5'd4);
      // R11, R5, R13
      apply(4'd13, 32'h0, 32'hffffabcd, 5'd0);
      apply(4'd7, 32'h0, 32'h0, 5'd0);
      apply(4'd14, 32'h7fffffff, 32'h1, 5'd3);
      apply(4'd15, 32'hffffffff, 32'hffffffff, 5'd3);
      // constrained random
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] x, y;
         logic [3:0]  o;
         int unsigned k;
         o = 4'($urandom_range(0, 15));
         x = $urandom();
         k = $urandom_range(0, 7);
         case (k)
            0, 1: y = x;
            2: y = x ^ 32'h80000000;
            3: y = 32'($urandom_range(0, 3));
            default: y = $urandom();
         endcase
         if (k == 4) x = {1'b0, 31'h7ffffff0} + 32'($urandom_range(0, 31));
         apply(o, x, y, 5'($urandom_range(0, 31)));
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule